// File: doc/BRIEF.md
# Coin Vending Controller

This block is a small synchronous state machine that runs the money side of a single-item vending machine priced at 20 cents. Each clock cycle it may take one coin, qualified by a valid strobe and named by a 2-bit code: a nickel worth 5 cents, a dime worth 10 cents or a quarter worth 25 cents. Credit below the price is held in a two-bit register that stands for 0, 5, 10 or 15 cents.

When an accepted coin brings the total to 20 cents or more, the block pulses a dispense output. In the same pulse it returns change through two separate outputs, one that returns a nickel and one that returns a dime. No more than 15 cents is paid back for one sale. Any remainder stays as credit toward the next sale. The only case with a remainder is 15 cents plus a quarter: it pays back a nickel and a dime and keeps 5 cents.

All outputs are registered. They rise in the cycle after the clock edge that samples the coin and last for exactly one cycle.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the credit to 0 cents and drives dispense, ret_nickel and ret_dime low.
- R2: Coin codes are 2'b00 for a nickel (5 cents), 2'b01 for a dime (10 cents) and 2'b10 for a quarter (25 cents). A valid quarter always causes a dispense.
- R3: When an accepted coin leaves the total below 20 cents, all three outputs stay 0 and the new total becomes the held credit.
- R4: A total of exactly 20 cents dispenses with no change (output {dispense, ret_nickel, ret_dime} = 3'b100) and leaves 0 cents of credit.
- R5: A total of 25 cents gives 3'b110 (dispense plus one nickel) and leaves 0 cents.
- R6: A total of 30 cents gives 3'b101 (dispense plus one dime) and leaves 0 cents.
- R7: A total of 35 cents gives 3'b111 (dispense, nickel and dime) and leaves 0 cents.
- R8: A total of 40 cents gives 3'b111 and keeps 5 cents of credit for the next sale.
- R9: A coin_vld cycle with code 2'b11 leaves the credit unchanged and drives all outputs to 0.
- R10: While coin_vld is low, the credit holds and all outputs are 0.
- R11: The outputs for a coin sampled at a clock edge appear right after that edge and last one cycle. Back-to-back sales give back-to-back dispense pulses.
- R12: A change output is never high unless dispense is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_vld | input | 1 | A coin is presented this cycle |
| coin_code | input | 2 | Coin type: 00 nickel, 01 dime, 10 quarter, 11 invalid |
| dispense | output | 1 | One-cycle pulse: release one item |
| ret_nickel | output | 1 | One-cycle pulse: return a nickel |
| ret_dime | output | 1 | One-cycle pulse: return a dime |

## Verification
Dispense, change return and carried credit can all land in one cycle. The hardest case is a quarter added to 15 cents: the item goes out, both change coins go out, and 5 cents must stay in the register. The bench reaches every starting credit, applies every code with the strobe both high and low, and compares the output triple with a value worked out from the coin sum. It then feeds nickels one at a time and counts how many it takes to reach the next dispense, which shows the credit left behind. Right after the coin it also checks that the outputs go low again after one cycle.

// File: rtl/vend_pkg.sv
package vend_pkg;

  typedef enum logic [1:0] {
    COIN_NICKEL  = 2'b00,
    COIN_DIME    = 2'b01,
    COIN_QUARTER = 2'b10,
    COIN_BAD     = 2'b11
  } coin_e;

  typedef struct packed {
    logic vend;
    logic give_nickel;
    logic give_dime;
  } pay_s;

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode #(
  parameter int VAL_W         = 3,
  parameter int NICKEL_UNITS  = 1,
  parameter int DIME_UNITS    = 2,
  parameter int QUARTER_UNITS = 5
) (
  input  logic             coin_vld,
  input  logic [1:0]       coin_code,
  output logic             accept,
  output logic [VAL_W-1:0] units
);
  import vend_pkg::*;

  always_comb begin
    accept = 1'b0;
    units  = '0;
    if (coin_vld) begin
      unique case (coin_e'(coin_code))
        COIN_NICKEL:  begin accept = 1'b1; units = VAL_W'(NICKEL_UNITS);  end
        COIN_DIME:    begin accept = 1'b1; units = VAL_W'(DIME_UNITS);    end
        COIN_QUARTER: begin accept = 1'b1; units = VAL_W'(QUARTER_UNITS); end
        default:      begin accept = 1'b0; units = '0;                    end
      endcase
    end
  end

endmodule

// File: rtl/vend_settle.sv
module vend_settle #(
  parameter int CREDIT_W    = 2,
  parameter int VAL_W       = 3,
  parameter int PRICE_UNITS = 4,
  parameter int DIME_UNITS  = 2
) (
  input  logic                credit,
  input  logic [CREDIT_W-1:0] credit_now,
  input  logic                accept,
  input  logic [VAL_W-1:0]    units,
  output logic [CREDIT_W-1:0] credit_next,
  output vend_pkg::pay_s      pay
);
  localparam int SUM_W = ((CREDIT_W > VAL_W) ? CREDIT_W : VAL_W) + 1;

  logic [SUM_W-1:0] total;
  logic [SUM_W-1:0] excess;
  logic [SUM_W-1:0] after_dime;
  logic [SUM_W-1:0] after_nickel;
  logic             dime_out;
  logic             nickel_out;

  always_comb begin
    total        = SUM_W'(credit_now) + SUM_W'(units);
    excess       = total - SUM_W'(PRICE_UNITS);
    dime_out     = (excess >= SUM_W'(DIME_UNITS));
    after_dime   = dime_out ? (excess - SUM_W'(DIME_UNITS)) : excess;
    nickel_out   = (after_dime != '0);
    after_nickel = nickel_out ? (after_dime - SUM_W'(1)) : after_dime;

    credit_next = credit_now;
    pay         = '0;
    if (accept && credit) begin
      if (total >= SUM_W'(PRICE_UNITS)) begin
        pay.vend        = 1'b1;
        pay.give_nickel = nickel_out;
        pay.give_dime   = dime_out;
        credit_next     = CREDIT_W'(after_nickel);
      end else begin
        credit_next = CREDIT_W'(total);
      end
    end
  end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl #(
  parameter int CREDIT_W    = 2,
  parameter int PRICE_UNITS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       coin_vld,
  input  logic [1:0] coin_code,
  output logic       dispense,
  output logic       ret_nickel,
  output logic       ret_dime
);
  import vend_pkg::*;

  localparam int VAL_W = 3;

  logic                accept;
  logic [VAL_W-1:0]    units;
  logic [CREDIT_W-1:0] credit_q;
  logic [CREDIT_W-1:0] credit_d;
  pay_s                pay_d;
  pay_s                pay_q;

  vend_coin_decode #(
    .VAL_W(VAL_W)
  ) u_decode (
    .coin_vld (coin_vld),
    .coin_code(coin_code),
    .accept   (accept),
    .units    (units)
  );

  vend_settle #(
    .CREDIT_W   (CREDIT_W),
    .VAL_W      (VAL_W),
    .PRICE_UNITS(PRICE_UNITS)
  ) u_settle (
    .credit     (1'b1),
    .credit_now (credit_q),
    .accept     (accept),
    .units      (units),
    .credit_next(credit_d),
    .pay        (pay_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      credit_q <= '0;
      pay_q    <= '0;
    end else begin
      credit_q <= credit_d;
      pay_q    <= pay_d;
    end
  end

  assign dispense   = pay_q.vend;
  assign ret_nickel = pay_q.give_nickel;
  assign ret_dime   = pay_q.give_dime;

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       coin_vld,
  input logic [1:0] coin_code,
  input logic       dispense,
  input logic       ret_nickel,
  input logic       ret_dime
);

  p_change_needs_vend_r12: assert property (@(posedge clk) disable iff (rst)
    (ret_nickel || ret_dime) |-> dispense);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !coin_vld |=> !(dispense || ret_nickel || ret_dime));

  p_bad_code_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (coin_vld && coin_code == 2'b11) |=> !(dispense || ret_nickel || ret_dime));

  p_quarter_vends_r2: assert property (@(posedge clk) disable iff (rst)
    (coin_vld && coin_code == 2'b10) |=> dispense);

  p_nickel_no_change_r4: assert property (@(posedge clk) disable iff (rst)
    (coin_vld && coin_code == 2'b00) |=> !(ret_nickel || ret_dime));

  p_dime_no_dime_back_r5: assert property (@(posedge clk) disable iff (rst)
    (coin_vld && coin_code == 2'b01) |=> !ret_dime);

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> !(dispense || ret_nickel || ret_dime));

endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .coin_vld  (coin_vld),
  .coin_code (coin_code),
  .dispense  (dispense),
  .ret_nickel(ret_nickel),
  .ret_dime  (ret_dime)
);

// File: tb/vend_ctrl_bench.sv
module vend_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       coin_vld = 1'b0;
  logic [1:0] coin_code = 2'b00;
  logic       dispense;
  logic       ret_nickel;
  logic       ret_dime;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vend_ctrl u_vend_ctrl (
    .clk       (clk),
    .rst       (rst),
    .coin_vld  (coin_vld),
    .coin_code (coin_code),
    .dispense  (dispense),
    .ret_nickel(ret_nickel),
    .ret_dime  (ret_dime)
  );

  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {dispense, ret_nickel, ret_dime};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: outputs actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic vld, input logic [1:0] code);
    @(negedge clk);
    coin_vld  = vld;
    coin_code = code;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    coin_vld = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // probe held credit c (in nickels): the (4-c)-th nickel must dispense
  task automatic probe(input string req, input int c);
    for (int k = 1; k <= 4 - c; k++) begin
      step(1'b1, 2'b00);
      check(req, (k == 4 - c) ? 3'b100 : 3'b000);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: outputs low under reset and right after it
    @(posedge clk);
    @(posedge clk);
    #1;
    check("R1", 3'b000);
    do_reset();
    step(1'b0, 2'b00);
    check("R1", 3'b000);
    probe("R1", 0);

    for (int c = 0; c < 4; c++) begin
      for (int code = 0; code < 4; code++) begin
        for (int v = 0; v < 2; v++) begin
          int         val;
          int         s;
          int         e;
          int         d;
          int         n;
          int         nc;
          logic [2:0] exp;
          string      req;
          do_reset();
          for (int i = 0; i < c; i++) begin
            step(1'b1, 2'b00);
            check("R3", 3'b000);
          end
          val = (code == 0) ? 1 : (code == 1) ? 2 : 5;
          if (v == 0 || code == 3) begin
            exp = 3'b000;
            nc  = c;
            req = (v == 0) ? "R10" : "R9";
          end else begin
            s = c + val;
            if (s >= 4) begin
              e  = s - 4;
              d  = (e >= 2) ? 1 : 0;
              n  = ((e - 2*d) >= 1) ? 1 : 0;
              nc = e - 2*d - n;
              exp = {1'b1, n[0], d[0]};
              case (e)
                0: req = "R4";
                1: req = "R5";
                2: req = "R6";
                3: req = "R7";
                default: req = "R8";
              endcase
              if (code == 2) req = {req, "/R2"};
            end else begin
              exp = 3'b000;
              nc  = s;
              req = "R3";
            end
          end
          step(v[0], code[1:0]);
          check(req, exp);
          step(1'b0, 2'b00);
          check("R11", 3'b000);
          probe(req, nc);
        end
      end
    end

    // R11/R8: back-to-back sales from 15 cents with quarters
    do_reset();
    for (int i = 0; i < 3; i++) step(1'b1, 2'b00);
    step(1'b1, 2'b10);
    check("R8", 3'b111);
    step(1'b1, 2'b10);
    check("R11", 3'b101);
    step(1'b1, 2'b01);
    check("R11", 3'b000);
    step(1'b1, 2'b01);
    check("R11", 3'b100);
    step(1'b0, 2'b10);
    check("R11", 3'b000);

    // R1: reset mid-credit clears it
    do_reset();
    step(1'b1, 2'b01);
    do_reset();
    probe("R1", 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule